// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block keeps the interrupt status byte and the interrupt enable (mask) byte of a packet network controller and drives one level-sensitive interrupt request. Event strobes from the receive path, the buffer allocator and the receive overrun detector latch their status bits. Two further bits are not only latched but re-forced every clock from queue occupancy. The transmit-queue-empty bit is forced while the transmit queue is empty. The transmit-complete bit is forced while the completion queue holds anything.

The host writes the status address to acknowledge interrupts. Only bits inside the acknowledge mask (default 0xD6) can be cleared this way. When an acknowledge write carries the transmit-complete bit, the block also issues a pop strobe to the completion queue. The queues are outside the block: they report their levels and take the pop strobe. Both bytes can be read back at all times. The interrupt output is registered by default.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status byte reads 0x04 (transmit-empty alone), the mask reads 0x00 and `irq` is low.
- R2: Status bit 2 (0x04, transmit-empty) is set at the next clock edge whenever `txq_level` is 0 at that edge, even if the same cycle acknowledges it.
- R3: Status bit 1 (0x02, transmit-complete) is set at the next clock edge whenever `txdq_level` is nonzero at that edge, even if the same cycle acknowledges it.
- R4: A write with `host_sel`=0 clears the status bits in `host_wdata & 0xD6` at the next edge. Bits 0 (0x01) and 3 (0x08), and every bit outside 0xD6, are left unchanged.
- R5: `txdq_pop` is high in the same cycle as an acknowledge write whose data has bit 1 set, and only while `txdq_level` is nonzero. It is low at all other times.
- R6: `ev_rx_done` sets bit 0 (0x01), `ev_alloc_done` sets bit 3 (0x08) and `ev_rx_overrun` sets bit 4 (0x10) at the next edge. An event wins over an acknowledge of the same bit in the same cycle.
- R7: On `rxq_pop`, `rxq_level` gives the receive-queue occupancy left after the pop. Bit 0 becomes 1 if that level is nonzero and 0 if it is zero. `ev_rx_done` in the same cycle keeps bit 0 set.
- R8: A write with `host_sel`=1 loads `host_wdata` into the mask at the next edge. The mask holds its value otherwise, and `mask_rd` shows it.
- R9: `irq` equals the OR of (status AND mask) as held by the registers one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | Write target: 0 acknowledge status, 1 mask |
| host_wdata | input | 8 | Host write data |
| ev_rx_done | input | 1 | Frame received event |
| ev_alloc_done | input | 1 | Buffer allocation finished event |
| ev_rx_overrun | input | 1 | Receive overrun event |
| rxq_pop | input | 1 | Receive queue head removed this cycle |
| rxq_level | input | LVL_W | Receive queue occupancy after the pop |
| txq_level | input | LVL_W | Transmit queue occupancy |
| txdq_level | input | LVL_W | Completion queue occupancy |
| status_rd | output | 8 | Status byte readback |
| mask_rd | output | 8 | Mask byte readback |
| txdq_pop | output | 1 | Pop strobe to the completion queue |
| irq | output | 1 | Interrupt request, active high |

## Verification
A wrong status bit shows on `status_rd` one edge after the cycle that produced it. It also reaches `irq` one edge later, but only if that bit is enabled in the mask. A bad acknowledge decode is visible in the same cycle on `txdq_pop`. A swapped set/clear priority only shows when an event or a queue level coincides with an acknowledge of the same bit, so the bench makes those collisions happen on purpose. The bench sweeps all 512 acknowledge/level combinations and all 256 mask values. It then runs a long pseudo-random run against an arithmetic model of the two bytes.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
   localparam int STAT_W = 8;
   localparam int B_RX    = 0;
   localparam int B_TX    = 1;
   localparam int B_TXE   = 2;
   localparam int B_ALLOC = 3;
   localparam int B_OVRN  = 4;
   localparam logic [STAT_W-1:0] ACK_CLEARABLE = 8'hD6;
   localparam logic [STAT_W-1:0] STATUS_AT_RESET = 8'h04;
endpackage

// File: rtl/irq_host_if.sv
module irq_host_if
   import irq_stat_pkg::*;
#(
   parameter int LVL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic              host_sel,
   input  logic [STAT_W-1:0] host_wdata,
   input  logic [LVL_W-1:0]  txdq_level,
   output logic              ack_we,
   output logic              mask_we,
   output logic              txdq_pop
);
   always_comb begin
      ack_we   = host_we && !host_sel;
      mask_we  = host_we && host_sel;
      txdq_pop = ack_we && host_wdata[B_TX] && (txdq_level != '0);
   end

   // R5: a pop only comes from an acknowledge carrying the transmit bit
   a_r5_pop_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
      txdq_pop |-> (host_we && !host_sel && host_wdata[B_TX]));
   a_r5_pop_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
      txdq_pop |-> (txdq_level != '0));
endmodule

// File: rtl/irq_stat_reg.sv
module irq_stat_reg
   import irq_stat_pkg::*;
#(
   parameter int                LVL_W    = 3,
   parameter logic [STAT_W-1:0] ACK_MASK = ACK_CLEARABLE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ack_we,
   input  logic [STAT_W-1:0] ack_val,
   input  logic              ev_rx,
   input  logic              ev_alloc,
   input  logic              ev_ovrn,
   input  logic              rx_pop,
   input  logic [LVL_W-1:0]  rxq_level,
   input  logic [LVL_W-1:0]  txq_level,
   input  logic [LVL_W-1:0]  txdq_level,
   output logic [STAT_W-1:0] status
);
   logic [STAT_W-1:0] set_v;
   logic [STAT_W-1:0] clr_v;

   always_comb begin
      set_v = '0;
      clr_v = '0;
      if (ack_we) clr_v = ack_val & ACK_MASK;
      if (rx_pop) begin
         if (rxq_level == '0) clr_v[B_RX] = 1'b1;
         else                 set_v[B_RX] = 1'b1;
      end
      set_v[B_RX]    = set_v[B_RX] | ev_rx;
      set_v[B_ALLOC] = ev_alloc;
      set_v[B_OVRN]  = ev_ovrn;
      set_v[B_TXE]   = (txq_level == '0);
      set_v[B_TX]    = (txdq_level != '0);
   end

   for (genvar b = 0; b < STAT_W; b++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk) begin
         if (!rst_n)         bit_q <= STATUS_AT_RESET[b];
         else if (set_v[b])  bit_q <= 1'b1;
         else if (clr_v[b])  bit_q <= 1'b0;
      end
      assign status[b] = bit_q;
   end

   // R2 / R3: forced bits follow queue levels
   a_r2_txe_forced: assert property (@(posedge clk) disable iff (!rst_n)
      (txq_level == '0) |=> status[B_TXE]);
   a_r3_tx_forced: assert property (@(posedge clk) disable iff (!rst_n)
      (txdq_level != '0) |=> status[B_TX]);
   // R4: the allocation bit cannot be acknowledged away
   a_r4_alloc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      status[B_ALLOC] |=> status[B_ALLOC]);
   // R6: overrun event sets its bit
   a_r6_ovrn_set: assert property (@(posedge clk) disable iff (!rst_n)
      ev_ovrn |=> status[B_OVRN]);
   // R7: a pop that empties the receive queue drops the receive bit
   a_r7_rx_empty_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pop && rxq_level == '0 && !ev_rx) |=> !status[B_RX]);
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
   import irq_stat_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mask_we,
   input  logic [STAT_W-1:0] mask_wdata,
   output logic [STAT_W-1:0] mask
);
   always_ff @(posedge clk) begin
      if (!rst_n)       mask <= '0;
      else if (mask_we) mask <= mask_wdata;
   end

   // R8: the mask only moves on its own write
   a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we |=> $stable(mask));
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage
   import irq_stat_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] status,
   input  logic [STAT_W-1:0] mask,
   output logic              irq
);
   logic pending;
   assign pending = |(status & mask);

   if (OUT_REG) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= pending;
      end
      assign irq = irq_q;
      // R9: output follows the masked status one clock later
      a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
         pending |=> irq);
      a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         !pending |=> !irq);
   end else begin : g_comb
      assign irq = pending;
   end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
   import irq_stat_pkg::*;
#(
   parameter int                DEPTH    = 4,
   parameter logic [STAT_W-1:0] ACK_MASK = ACK_CLEARABLE,
   parameter bit                OUT_REG  = 1'b1,
   localparam int               LVL_W    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic              host_sel,
   input  logic [7:0]        host_wdata,
   input  logic              ev_rx_done,
   input  logic              ev_alloc_done,
   input  logic              ev_rx_overrun,
   input  logic              rxq_pop,
   input  logic [LVL_W-1:0]  rxq_level,
   input  logic [LVL_W-1:0]  txq_level,
   input  logic [LVL_W-1:0]  txdq_level,
   output logic [7:0]        status_rd,
   output logic [7:0]        mask_rd,
   output logic              txdq_pop,
   output logic              irq
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("irq_status_ctrl: DEPTH must be at least 1");
   end

   logic ack_we;
   logic mask_we;
   logic [STAT_W-1:0] status;
   logic [STAT_W-1:0] mask;

   irq_host_if #(.LVL_W(LVL_W)) u_host (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
      .host_wdata(host_wdata), .txdq_level(txdq_level),
      .ack_we(ack_we), .mask_we(mask_we), .txdq_pop(txdq_pop)
   );

   irq_stat_reg #(.LVL_W(LVL_W), .ACK_MASK(ACK_MASK)) u_stat (
      .clk(clk), .rst_n(rst_n), .ack_we(ack_we), .ack_val(host_wdata),
      .ev_rx(ev_rx_done), .ev_alloc(ev_alloc_done), .ev_ovrn(ev_rx_overrun),
      .rx_pop(rxq_pop), .rxq_level(rxq_level), .txq_level(txq_level),
      .txdq_level(txdq_level), .status(status)
   );

   irq_mask_reg u_mask (
      .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_wdata(host_wdata),
      .mask(mask)
   );

   irq_out_stage #(.OUT_REG(OUT_REG)) u_out (
      .clk(clk), .rst_n(rst_n), .status(status), .mask(mask), .irq(irq)
   );

   assign status_rd = status;
   assign mask_rd   = mask;

   // R1: reset leaves the status at transmit-empty alone
   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> (status_rd == STATUS_AT_RESET && mask_rd == '0));
endmodule

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;
   localparam int DEPTH = 4;
   localparam int LVL_W = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0;
   logic host_we = 0, host_sel = 0;
   logic [7:0] host_wdata = 0;
   logic ev_rx_done = 0, ev_alloc_done = 0, ev_rx_overrun = 0, rxq_pop = 0;
   logic [LVL_W-1:0] rxq_level = 0, txq_level = 1, txdq_level = 0;
   logic [7:0] status_rd, mask_rd;
   logic txdq_pop, irq;

   irq_status_ctrl #(.DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
      .host_wdata(host_wdata), .ev_rx_done(ev_rx_done),
      .ev_alloc_done(ev_alloc_done), .ev_rx_overrun(ev_rx_overrun),
      .rxq_pop(rxq_pop), .rxq_level(rxq_level), .txq_level(txq_level),
      .txdq_level(txdq_level), .status_rd(status_rd), .mask_rd(mask_rd),
      .txdq_pop(txdq_pop), .irq(irq)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   logic [7:0] m_st = 8'h04, m_mk = 8'h00;
   logic m_irq = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic idle();
      host_we = 0; host_sel = 0; host_wdata = 0;
      ev_rx_done = 0; ev_alloc_done = 0; ev_rx_overrun = 0; rxq_pop = 0;
   endtask

   // one clock: inputs already driven; model update from the requirements
   task automatic step(input string tag);
      logic [7:0] st;
      logic exp_pop;
      #1;
      exp_pop = host_we && !host_sel && host_wdata[1] && (txdq_level != 0);
      chk(txdq_pop == exp_pop, "R5 pop strobe", txdq_pop, exp_pop);
      st = m_st;
      if (host_we && !host_sel) st = st & ~(host_wdata & 8'hD6);
      if (rxq_pop) st[0] = (rxq_level != 0);
      if (ev_rx_done) st[0] = 1'b1;
      if (ev_alloc_done) st[3] = 1'b1;
      if (ev_rx_overrun) st[4] = 1'b1;
      if (txq_level == 0) st[2] = 1'b1;
      if (txdq_level != 0) st[1] = 1'b1;
      m_irq = |(m_st & m_mk);
      if (host_we && host_sel) m_mk = host_wdata;
      m_st = st;
      @(posedge clk);
      @(negedge clk);
      chk(status_rd == m_st, tag, status_rd, m_st);
      chk(mask_rd == m_mk, "R8 mask readback", mask_rd, m_mk);
      chk(irq == m_irq, "R9 irq", irq, m_irq);
      idle();
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(status_rd == 8'h04, "R1 status", status_rd, 8'h04);
      chk(mask_rd == 8'h00, "R1 mask", mask_rd, 8'h00);
      chk(irq == 1'b0, "R1 irq", irq, 0);

      // R2: empty transmit queue forces 0x04 against an acknowledge
      txq_level = 0; host_we = 1; host_wdata = 8'h04; step("R2 txe forced");
      txq_level = 1; host_we = 1; host_wdata = 8'h04; step("R2 txe acked");
      chk(status_rd[2] == 1'b0, "R2 txe cleared", status_rd, 0);

      // R3 / R5: completion queue forces 0x02, ack pops it
      txdq_level = 2; step("R3 tx forced");
      host_we = 1; host_wdata = 8'h02; step("R3 tx held while queued");
      txdq_level = 0; host_we = 1; host_wdata = 8'h02; step("R3 tx acked when empty");
      chk(status_rd[1] == 1'b0, "R3 tx cleared", status_rd, 0);

      // R6: events, set wins over acknowledge
      ev_rx_overrun = 1; host_we = 1; host_wdata = 8'h10; step("R6 overrun beats ack");
      ev_alloc_done = 1; step("R6 alloc set");
      host_we = 1; host_wdata = 8'hFF; step("R4 alloc and rx survive ack");
      chk(status_rd[3] == 1'b1, "R4 alloc kept", status_rd, 8'h08);

      // R7: receive pop behaviour
      ev_rx_done = 1; step("R6 rx set");
      rxq_pop = 1; rxq_level = 2; step("R7 pop leaves entries");
      rxq_pop = 1; rxq_level = 0; step("R7 pop empties");
      chk(status_rd[0] == 1'b0, "R7 rx cleared", status_rd, 0);
      rxq_pop = 1; rxq_level = 0; ev_rx_done = 1; step("R7 event beats pop");

      // R8 / R9: all mask values, with an idle cycle to see irq
      for (int m = 0; m < 256; m++) begin
         host_we = 1; host_sel = 1; host_wdata = m[7:0]; step("R8 mask write");
         step("R9 irq settle");
      end

      // R4: every acknowledge value with and without a completion entry
      for (int v = 0; v < 512; v++) begin
         ev_rx_done = 1; ev_alloc_done = 1; ev_rx_overrun = 1;
         txq_level = 0; txdq_level = 1; step("R6 refill");
         txq_level = 1; txdq_level = v[8] ? 3'd1 : 3'd0;
         host_we = 1; host_wdata = v[7:0]; step("R4 ack sweep");
      end

      // pseudo-random run against the model
      lfsr = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         host_we = lfsr[0] & lfsr[5];
         host_sel = lfsr[1] & lfsr[7];
         host_wdata = lfsr[15:8] ^ lfsr[7:0];
         ev_rx_done = lfsr[2] & lfsr[9];
         ev_alloc_done = lfsr[3] & lfsr[11] & lfsr[6];
         ev_rx_overrun = lfsr[4] & lfsr[12] & lfsr[1];
         rxq_pop = lfsr[6] & lfsr[14];
         rxq_level = LVL_W'(lfsr[10:8] % 5);
         txq_level = LVL_W'(lfsr[13:11] % 5);
         txdq_level = LVL_W'(lfsr[4:2] % 5);
         step("R4 random sweep");
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule